// File: doc/BRIEF.md
# Corner Integral Map Builder

This block turns a raster stream of one-bit corner flags into a summed-area map of corner counts for a 32x32 frame. For every pixel it writes one entry holding the number of flagged pixels inside the rectangle from the top-left corner of the frame down to and including that pixel. A classifier can then count the corners in any rectangle from four of these entries.

The map is not kept in storage of its own. It goes into the shared frame buffer, which the image sensor leaves idle while the system harvests energy. A phase input says which phase is running. While the sensor is imaging, the block refuses input and keeps its state frozen. It resumes where it stopped once harvesting returns. Inside, the block keeps a running sum for the current row and a one-row line buffer holding the entries of the row above. Each entry is the row's running sum plus the entry directly above it.

Top module: `corner_integral_builder`

## Requirements
- R1: Every entry written equals the number of flagged pixels at column <= x and row <= y of the current frame; an all-ones frame ends with the value 1024 at the last pixel.
- R2: The write address of pixel (x, y) is y*32 + x. Exactly one write is made per accepted pixel, in raster order.
- R3: `pix_ready_o` is 1 exactly when `harvest_i` is 1. A beat offered while `harvest_i` is 0 is not taken.
- R4: `mem_we_o` is never 1 while `harvest_i` is 0. A write still pending when imaging begins is held, with its address and data, until harvesting returns.
- R5: When `harvest_i` stays 1, the write for an accepted pixel appears in the cycle right after the clock edge that accepted it.
- R6: An accepted beat with `sof_i` = 1 is pixel (0, 0) of a new frame, and any partly built frame is abandoned.
- R7: In row 0 the entry above is taken as zero. The row running sum starts again at column 0 of every row.
- R8: `frame_done_o` is a single-cycle pulse. It comes in the cycle after the write to address 1023.
- R9: A beat accepted with `sof_i` = 0 when no frame is open (after reset or after a completed frame) is discarded and produces no write.
- R10: After reset `mem_we_o` and `frame_done_o` are 0 and no frame is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| harvest_i | input | 1 | 1 = harvesting phase (buffer free), 0 = imaging phase |
| pix_valid_i | input | 1 | Corner flag beat is valid |
| pix_sof_i | input | 1 | Beat is the first pixel of a frame |
| pix_corner_i | input | 1 | Corner flag of the pixel |
| pix_ready_o | output | 1 | Block accepts a beat this cycle |
| mem_we_o | output | 1 | Frame-buffer write enable |
| mem_addr_o | output | 10 | Frame-buffer word address |
| mem_wdata_o | output | 11 | Integral entry to store |
| frame_done_o | output | 1 | Pulse after the last entry of a frame is written |

## Verification
Two things can land in the same cycle. The first is a switch to imaging in the cycle right after a pixel was accepted, while that pixel's write is still pending. The bench provokes it by lowering the phase directly after accepted beats, sometimes for several cycles. It judges the result by requiring no write during imaging and the held entry to come out unchanged on the first harvesting cycle. The second is a new beat being accepted in the same cycle the previous entry drains to memory. A behavioural model predicts every write and every done pulse cycle by cycle, so any lost or duplicated entry is reported.

// File: rtl/cib_pkg.sv
package cib_pkg;
  // Default geometry of the corner map.
  localparam int unsigned DEF_W = 32;
  localparam int unsigned DEF_H = 32;

  // Bits needed to hold values 0..n.
  function automatic int unsigned bits_for(input int unsigned n);
    int unsigned b;
    b = 1;
    while ((1 << b) <= n) b++;
    return b;
  endfunction
endpackage

// File: rtl/cib_coord.sv
module cib_coord #(
  parameter int unsigned FRAME_W = 32,
  parameter int unsigned FRAME_H = 32,
  localparam int unsigned X_W = $clog2(FRAME_W),
  localparam int unsigned Y_W = $clog2(FRAME_H)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic           sof,
  output logic           acc,
  output logic [X_W-1:0] col,
  output logic [Y_W-1:0] row,
  output logic           at_col0,
  output logic           at_row0,
  output logic           at_last
);
  logic [X_W-1:0] x_q, x_n;
  logic [Y_W-1:0] y_q, y_n;
  logic           open_q, open_n;
  logic           end_col, end_row;

  always_comb begin
    col     = sof ? '0 : x_q;
    row     = sof ? '0 : y_q;
    acc     = take & (sof | open_q);
    at_col0 = (col == '0);
    at_row0 = (row == '0);
    end_col = (col == X_W'(FRAME_W - 1));
    end_row = (row == Y_W'(FRAME_H - 1));
    at_last = end_col & end_row;
  end

  always_comb begin
    x_n    = x_q;
    y_n    = y_q;
    open_n = open_q;
    if (acc) begin
      open_n = 1'b1;
      if (end_col) begin
        x_n = '0;
        if (end_row) begin
          y_n    = '0;
          open_n = 1'b0;
        end else begin
          y_n = row + Y_W'(1);
        end
      end else begin
        x_n = col + X_W'(1);
        y_n = row;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      open_q <= 1'b0;
    end else if (acc) begin
      x_q    <= x_n;
      y_q    <= y_n;
      open_q <= open_n;
    end
  end
endmodule

// File: rtl/cib_linebuf.sv
module cib_linebuf #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 11,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cell_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic hit;
    assign hit = wr_en & (idx == IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q[i] <= '0;
      end else if (hit) begin
        cell_q[i] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (idx == IW'(i)) rdata = cell_q[i];
    end
  end
endmodule

// File: rtl/cib_accum.sv
module cib_accum #(
  parameter int unsigned FRAME_W = 32,
  parameter int unsigned CNT_W   = 11,
  localparam int unsigned ROW_W  = $clog2(FRAME_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             corner,
  input  logic             at_col0,
  input  logic             at_row0,
  input  logic [CNT_W-1:0] above,
  output logic [CNT_W-1:0] sum
);
  logic [ROW_W-1:0] run_q, run_n;

  always_comb begin
    run_n = (at_col0 ? '0 : run_q) + ROW_W'(corner);
    sum   = CNT_W'(run_n) + (at_row0 ? '0 : above);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (acc) begin
      run_q <= run_n;
    end
  end
endmodule

// File: rtl/cib_wr_port.sv
module cib_wr_port #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned CNT_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [CNT_W-1:0]  data_in,
  input  logic              last_in,
  input  logic              harvest,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [CNT_W-1:0]  mem_wdata,
  output logic              done
);
  logic              pend_q, pend_n;
  logic              last_q;
  logic              done_q, done_n;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  data_q;

  always_comb begin
    mem_we    = pend_q & harvest;
    mem_addr  = addr_q;
    mem_wdata = data_q;
    pend_n    = acc | (pend_q & ~harvest);
    done_n    = mem_we & last_q;
    done      = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pend_q <= pend_n;
      done_q <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      last_q <= 1'b0;
    end else if (acc) begin
      addr_q <= addr_in;
      data_q <= data_in;
      last_q <= last_in;
    end
  end
endmodule

// File: rtl/corner_integral_builder.sv
module corner_integral_builder #(
  parameter int unsigned FRAME_W = cib_pkg::DEF_W,
  parameter int unsigned FRAME_H = cib_pkg::DEF_H,
  localparam int unsigned X_W    = $clog2(FRAME_W),
  localparam int unsigned Y_W    = $clog2(FRAME_H),
  localparam int unsigned ADDR_W = $clog2(FRAME_W * FRAME_H),
  localparam int unsigned CNT_W  = cib_pkg::bits_for(FRAME_W * FRAME_H)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              harvest_i,
  input  logic              pix_valid_i,
  input  logic              pix_sof_i,
  input  logic              pix_corner_i,
  output logic              pix_ready_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [CNT_W-1:0]  mem_wdata_o,
  output logic              frame_done_o
);
  logic              take, acc;
  logic [X_W-1:0]    col;
  logic [Y_W-1:0]    row;
  logic              at_col0, at_row0, at_last;
  logic [CNT_W-1:0]  above, sum;
  logic [ADDR_W-1:0] addr;

  assign pix_ready_o = harvest_i;
  assign take        = pix_valid_i & harvest_i;
  assign addr        = ADDR_W'(row) * ADDR_W'(FRAME_W) + ADDR_W'(col);

  cib_coord #(.FRAME_W(FRAME_W), .FRAME_H(FRAME_H)) u_coord (
    .clk(clk), .rst_n(rst_n), .take(take), .sof(pix_sof_i),
    .acc(acc), .col(col), .row(row),
    .at_col0(at_col0), .at_row0(at_row0), .at_last(at_last)
  );

  cib_linebuf #(.DEPTH(FRAME_W), .DW(CNT_W)) u_line (
    .clk(clk), .rst_n(rst_n), .wr_en(acc), .idx(col),
    .wdata(sum), .rdata(above)
  );

  cib_accum #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .acc(acc), .corner(pix_corner_i),
    .at_col0(at_col0), .at_row0(at_row0), .above(above), .sum(sum)
  );

  cib_wr_port #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .acc(acc), .addr_in(addr), .data_in(sum),
    .last_in(at_last), .harvest(harvest_i),
    .mem_we(mem_we_o), .mem_addr(mem_addr_o), .mem_wdata(mem_wdata_o),
    .done(frame_done_o)
  );
endmodule

// File: rtl/cib_checker.sv
module cib_checker #(
  parameter int unsigned FRAME_W = 32,
  parameter int unsigned FRAME_H = 32,
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned CNT_W   = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              harvest_i,
  input logic              pix_ready_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [CNT_W-1:0]  mem_wdata_o,
  input logic              frame_done_o
);
  localparam int unsigned LAST = FRAME_W * FRAME_H - 1;

  logic [31:0] bound;
  assign bound = (32'(mem_addr_o) % FRAME_W + 1) * (32'(mem_addr_o) / FRAME_W + 1);

  assert_ready_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !harvest_i |-> !pix_ready_o);

  assert_no_write_imaging_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> harvest_i);

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> $past(mem_we_o && (mem_addr_o == ADDR_W'(LAST))));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o);

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (32'(mem_wdata_o) <= bound));

  assert_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && mem_addr_o == '0) |-> (mem_wdata_o <= CNT_W'(1)));

  assert_held_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pix_ready_o) == 1'b0 && !harvest_i) |-> $stable(mem_addr_o) && $stable(mem_wdata_o));
endmodule

bind corner_integral_builder cib_checker #(
  .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_cib_chk (
  .clk(clk), .rst_n(rst_n), .harvest_i(harvest_i), .pix_ready_o(pix_ready_o),
  .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
  .frame_done_o(frame_done_o)
);

// File: tb/corner_integral_builder_bench.sv
`timescale 1ns/1ps
module corner_integral_builder_bench;
  localparam int W = 32;
  localparam int H = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic harvest_i, pix_valid_i, pix_sof_i, pix_corner_i;
  logic pix_ready_o, mem_we_o, frame_done_o;
  logic [9:0]  mem_addr_o;
  logic [10:0] mem_wdata_o;

  always #5 clk = ~clk;

  corner_integral_builder u_corner_integral_builder (
    .clk(clk), .rst_n(rst_n), .harvest_i(harvest_i),
    .pix_valid_i(pix_valid_i), .pix_sof_i(pix_sof_i), .pix_corner_i(pix_corner_i),
    .pix_ready_o(pix_ready_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .frame_done_o(frame_done_o)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference model
  int  flag [H][W];
  int  mx = 0, my = 0;
  bit  mopen = 0;
  int  q_addr[$];
  int  q_data[$];
  bit  q_last[$];
  bit  q_restart[$];
  bit  exp_done = 0;
  bit  model_on = 0;

  always @(posedge clk) begin
    if (model_on && pix_valid_i && harvest_i && (pix_sof_i || mopen)) begin
      int s;
      bit restart;
      restart = pix_sof_i && mopen;
      if (pix_sof_i) begin mx = 0; my = 0; end
      flag[my][mx] = pix_corner_i ? 1 : 0;
      s = 0;
      for (int yy = 0; yy <= my; yy++)
        for (int xx = 0; xx <= mx; xx++) s += flag[yy][xx];
      q_addr.push_back(my * W + mx);
      q_data.push_back(s);
      q_last.push_back(mx == W - 1 && my == H - 1);
      q_restart.push_back(restart);
      mopen = 1;
      if (mx == W - 1) begin
        mx = 0;
        if (my == H - 1) begin my = 0; mopen = 0; end
        else my++;
      end else mx++;
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      bit want_we;
      check(pix_ready_o == harvest_i, "R3 ready", pix_ready_o, harvest_i);
      want_we = (q_addr.size() > 0) && harvest_i;
      if (q_addr.size() == 0)
        check(mem_we_o == 1'b0, "R9 no write", mem_we_o, 0);
      else if (!harvest_i)
        check(mem_we_o == 1'b0, "R4 held", mem_we_o, 0);
      else
        check(mem_we_o == 1'b1, "R5 write timing", mem_we_o, 1);
      check(frame_done_o == exp_done, "R8 done", frame_done_o, exp_done);
      exp_done = 0;
      if (want_we && mem_we_o) begin
        int a, d;
        bit lst, rs;
        a = q_addr.pop_front();
        d = q_data.pop_front();
        lst = q_last.pop_front();
        rs = q_restart.pop_front();
        check(mem_addr_o == a, "R2 address", mem_addr_o, a);
        if (a < W || a % W == 0)
          check(mem_wdata_o == d, "R7 edge entry", mem_wdata_o, d);
        else
          check(mem_wdata_o == d, "R1 entry", mem_wdata_o, d);
        if (rs) check(mem_addr_o == 0, "R6 restart", mem_addr_o, 0);
        exp_done = lst;
      end
    end
  end

  // Stimulus helpers: inputs change 2 ns after a rising edge
  task automatic step(input bit v, input bit s, input bit f, input bit h);
    pix_valid_i = v; pix_sof_i = s; pix_corner_i = f; harvest_i = h;
    @(posedge clk); #2;
  endtask

  int stall_mode = 0;
  int beat_n = 0;

  task automatic send(input bit s, input bit f);
    beat_n++;
    if (stall_mode != 0 && beat_n % 5 == 0) step(1, s, f, 0);
    step(1, s, f, 1);
    if (stall_mode != 0 && beat_n % 7 == 3) begin
      step(0, 0, 0, 0);
      step(1, 0, 1, 0);
      step(0, 0, 0, 0);
    end
    if (beat_n % 11 == 4) step(0, 0, 1, 1);
  endtask

  function automatic bit pat(input int p, input int x, input int y);
    case (p)
      0: return ((x * 7 + y * 3) % 5) == 0;
      1: return 1'b1;
      2: return ((x ^ y) & 1) == 1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic frame(input int p, input int npix);
    for (int i = 0; i < npix; i++)
      send(i == 0, pat(p, i % W, i / W));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    harvest_i = 1'b1; pix_valid_i = 1'b0; pix_sof_i = 1'b0; pix_corner_i = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check(mem_we_o == 1'b0, "R10 reset we", mem_we_o, 0);
    check(frame_done_o == 1'b0, "R10 reset done", frame_done_o, 0);
    rst_n = 1'b1;
    model_on = 1;
    // R10/R9: beats without start-of-frame after reset are discarded
    step(1, 0, 1, 1);
    step(1, 0, 1, 1);
    step(0, 0, 0, 1);
    // R1/R2: plain frame
    frame(0, W * H);
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    // R4/R5: all-ones frame with phase changes, ends with 1024 (R1)
    stall_mode = 1;
    frame(1, W * H);
    stall_mode = 0;
    step(0, 0, 0, 1);
    // R9: stray beats after a finished frame
    step(1, 0, 1, 1);
    step(1, 0, 0, 1);
    step(0, 0, 0, 1);
    // R6: partial frame abandoned by a new start-of-frame
    frame(2, 3 * W + 5);
    stall_mode = 1;
    frame(2, W * H);
    stall_mode = 0;
    repeat (4) step(0, 0, 0, 1);
    check(q_addr.size() == 0, "R2 drained", q_addr.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule